// File: doc/BRIEF.md
# Multi-Source Synchronous Reset Generator

This block merges several independent, asynchronous, active-low reset requests (for example a host-bus reset and a push button) into a single active-high reset for the system clock domain. Each request first passes through its own multi-flop synchroniser. The synchronised requests are ORed together with a power-up timer that holds reset asserted for a set number of clocks after device configuration. The merged reset then passes through a retiming pipeline of configurable depth, which eases the fanout of the global reset net.

The power-up timer has no reset input. It starts from its parameterised load value through register initial values and counts down once per clock. When it reaches zero it stays there, so after power-up only the external requests can assert the reset again. A pipeline depth of zero passes the merged reset straight to the output.

Top module: `rsg_reset_gen`

## Requirements
- R1: From configuration, `rst_o` is high, and with every request released it stays high until exactly `PWRUP_CYCLES + OUT_DEPTH` rising clock edges have occurred, then goes low.
- R2: Each bit of `rst_req_n_i` is active-low. Holding any single bit at 0 drives `rst_o` high.
- R3: A request that goes low reaches `rst_o` (high) exactly `SYNC_STAGES + OUT_DEPTH` rising edges after the first edge that samples it low.
- R4: When the last request is released, `rst_o` goes low exactly `SYNC_STAGES + OUT_DEPTH` rising edges after the first edge that samples it high.
- R5: While any other request remains low, releasing one request has no effect on `rst_o`, which stays high.
- R6: Once the power-up countdown has expired it never restarts: with all requests released, `rst_o` stays low indefinitely.
- R7: With `OUT_DEPTH = 0`, the merged reset drives `rst_o` directly. The power-up release then falls after `PWRUP_CYCLES` edges and the request latency is `SYNC_STAGES` edges.
- R8: A request held low for exactly one clock period produces a `rst_o` pulse exactly one clock period wide, delayed by the R3 latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; all outputs are synchronous to it |
| rst_req_n_i | input | NUM_SRC | Asynchronous active-low reset requests, one bit per source |
| rst_o | output | 1 | Merged active-high reset, synchronous to `clk_i` |

## Verification
The main function is driven with each source asserted on its own. This shows that every bit is wired through its own synchroniser and counts as active-low. Overlapping requests released in staggered order separate a true OR merge from logic that follows only the most recent request. A single-period request shows that nothing stretches or drops the pulse. A second instance with zero pipeline depth runs beside the main one on the same stimulus, so the power-up release edge and the request latency are each measured against two different pipeline depths.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  // Width needed to hold a countdown load value.
  function automatic int unsigned cnt_width(input int unsigned load);
    return (load < 2) ? 1 : $clog2(load + 1);
  endfunction

  // Edges from an input change being sampled to the output reflecting it.
  function automatic int unsigned req_latency(input int unsigned sync_stages,
                                              input int unsigned out_depth);
    return sync_stages + out_depth;
  endfunction

  // Edges from configuration until the output first releases.
  function automatic int unsigned pwrup_release(input int unsigned load,
                                                input int unsigned out_depth);
    return load + out_depth;
  endfunction

endpackage

// File: rtl/rsg_sync_cell.sv
module rsg_sync_cell #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic req_n_async_i,
  output logic req_sync_o
);
  localparam int unsigned LAST = STAGES - 1;

  // Active-high request chain; starts asserted at configuration.
  logic [LAST:0] chain_q = '1;

  always_ff @(posedge clk_i) begin
    chain_q[0] <= ~req_n_async_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign req_sync_o = chain_q[LAST];
endmodule

// File: rtl/rsg_pwrup_timer.sv
module rsg_pwrup_timer #(
  parameter int unsigned LOAD = 1000
) (
  input  logic                               clk_i,
  output logic [rsg_pkg::cnt_width(LOAD)-1:0] cnt_o,
  output logic                               busy_o
);
  localparam int unsigned CW = rsg_pkg::cnt_width(LOAD);
  localparam logic [CW-1:0] LOAD_V = CW'(LOAD);

  logic [CW-1:0] cnt_q = LOAD_V;
  logic          busy;

  assign busy = (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (busy) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign busy_o = busy;
endmodule

// File: rtl/rsg_out_pipe.sv
module rsg_out_pipe #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_comb_i,
  output logic rst_o
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign rst_o = rst_comb_i;
    end else begin : g_regs
      logic [DEPTH-1:0] pipe_q = '1;
      always_ff @(posedge clk_i) begin
        pipe_q[0] <= rst_comb_i;
      end
      for (genvar d = 1; d < DEPTH; d++) begin : g_stage
        always_ff @(posedge clk_i) begin
          pipe_q[d] <= pipe_q[d-1];
        end
      end
      assign rst_o = pipe_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/rsg_reset_gen.sv
module rsg_reset_gen #(
  parameter int unsigned NUM_SRC      = 2,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned PWRUP_CYCLES = 1000,
  parameter int unsigned OUT_DEPTH    = 3
) (
  input  logic               clk_i,
  input  logic [NUM_SRC-1:0] rst_req_n_i,
  output logic               rst_o
);
  localparam int unsigned CW = rsg_pkg::cnt_width(PWRUP_CYCLES);

  // Named internal events, observed by the bound checker.
  logic [NUM_SRC-1:0] sync_req;
  logic               any_req;
  logic [CW-1:0]      pwr_cnt;
  logic               pwr_busy;
  logic               comb_rst;

  generate
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      rsg_sync_cell #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i         (clk_i),
        .req_n_async_i (rst_req_n_i[k]),
        .req_sync_o    (sync_req[k])
      );
    end
  endgenerate

  rsg_pwrup_timer #(.LOAD(PWRUP_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .cnt_o  (pwr_cnt),
    .busy_o (pwr_busy)
  );

  assign any_req  = |sync_req;
  assign comb_rst = any_req | pwr_busy;

  rsg_out_pipe #(.DEPTH(OUT_DEPTH)) u_pipe (
    .clk_i      (clk_i),
    .rst_comb_i (comb_rst),
    .rst_o      (rst_o)
  );
endmodule

// File: rtl/rsg_reset_gen_chk.sv
module rsg_reset_gen_chk #(
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned CW      = 1
) (
  input logic               clk_i,
  input logic [NUM_SRC-1:0] sync_req,
  input logic [CW-1:0]      pwr_cnt,
  input logic               pwr_busy,
  input logic               rst_o
);
  logic armed = 1'b0;
  always_ff @(posedge clk_i) armed <= 1'b1;

  // R1: the timer steps down by one per clock while running
  a_r1_count_step: assert property (@(posedge clk_i) disable iff (!armed)
    pwr_busy |=> (pwr_cnt == $past(pwr_cnt) - 1'b1));

  // R1: output held high while the power-up timer runs
  a_r1_busy_holds_rst: assert property (@(posedge clk_i) disable iff (!armed)
    pwr_busy |-> rst_o);

  // R6: the countdown never restarts once expired
  a_r6_no_restart: assert property (@(posedge clk_i) disable iff (!armed)
    !pwr_busy |=> !pwr_busy);

  // R4: the output only releases after the timer has expired
  a_r4_release_after_timer: assert property (@(posedge clk_i) disable iff (!armed)
    $fell(rst_o) |-> !pwr_busy);

  // R2: a synchronised request is never flagged with the timer counting up
  a_r2_cnt_bounded: assert property (@(posedge clk_i) disable iff (!armed)
    (|sync_req) |=> (pwr_cnt <= $past(pwr_cnt)));
endmodule

bind rsg_reset_gen rsg_reset_gen_chk #(
  .NUM_SRC (NUM_SRC),
  .CW      (CW)
) u_chk (
  .clk_i    (clk_i),
  .sync_req (sync_req),
  .pwr_cnt  (pwr_cnt),
  .pwr_busy (pwr_busy),
  .rst_o    (rst_o)
);

// File: tb/test_rsg_reset_gen.sv
module test_rsg_reset_gen;
  localparam int unsigned N  = 3;
  localparam int unsigned S  = 2;
  localparam int unsigned P  = 20;
  localparam int unsigned D  = 3;
  localparam int unsigned L  = S + D;   // request latency, main instance
  localparam int unsigned L0 = S;       // request latency, depth-zero instance

  logic         clk = 1'b0;
  logic [N-1:0] req_n = '1;
  logic         rst_main;
  logic         rst_d0;
  int           edges = 0;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) edges <= edges + 1;

  rsg_reset_gen #(.NUM_SRC(N), .SYNC_STAGES(S), .PWRUP_CYCLES(P), .OUT_DEPTH(D))
    i_rsg_reset_gen (.clk_i(clk), .rst_req_n_i(req_n), .rst_o(rst_main));

  rsg_reset_gen #(.NUM_SRC(N), .SYNC_STAGES(S), .PWRUP_CYCLES(P), .OUT_DEPTH(0))
    i_rsg_reset_gen_d0 (.clk_i(clk), .rst_req_n_i(req_n), .rst_o(rst_d0));

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at edge %0d: actual %b expected %b", req, edges, act, exp);
    end
  endtask

  task automatic t_powerup();
    check(rst_main, 1'b1, "R1 initial");
    check(rst_d0, 1'b1, "R7 initial");
    while (edges < int'(P + D + 2)) begin
      @(negedge clk);
      if (edges == int'(P - 1)) check(rst_d0, 1'b1, "R7 before release");
      if (edges == int'(P))     check(rst_d0, 1'b0, "R7 release");
      if (edges == int'(P + D - 1)) check(rst_main, 1'b1, "R1 before release");
      if (edges == int'(P + D))     check(rst_main, 1'b0, "R1 release");
    end
  endtask

  // Single source asserted then released; checks R2, R3, R4 and R7 latency.
  task automatic t_single(input int k);
    @(negedge clk);
    req_n[k] = 1'b0;
    for (int i = 1; i <= int'(L); i++) begin
      @(negedge clk);
      if (i == int'(L0 - 1)) check(rst_d0, 1'b0, "R7 assert early");
      if (i == int'(L0))     check(rst_d0, 1'b1, "R7 assert");
      if (i == int'(L - 1))  check(rst_main, 1'b0, "R3 assert early");
      if (i == int'(L))      check(rst_main, 1'b1, "R2 R3 assert");
    end
    repeat (4) @(negedge clk);
    req_n[k] = 1'b1;
    for (int i = 1; i <= int'(L); i++) begin
      @(negedge clk);
      if (i == int'(L - 1)) check(rst_main, 1'b1, "R4 release early");
      if (i == int'(L))     check(rst_main, 1'b0, "R4 release");
    end
  endtask

  task automatic t_overlap();
    @(negedge clk);
    req_n[0] = 1'b0;
    repeat (3) @(negedge clk);
    req_n[2] = 1'b0;
    repeat (3) @(negedge clk);
    req_n[0] = 1'b1;
    repeat (L + 3) @(negedge clk);
    check(rst_main, 1'b1, "R5 other held");
    check(rst_d0, 1'b1, "R5 other held d0");
    req_n[2] = 1'b1;
    repeat (L - 1) @(negedge clk);
    check(rst_main, 1'b1, "R5 last release early");
    @(negedge clk);
    check(rst_main, 1'b0, "R5 last release");
  endtask

  task automatic t_pulse();
    @(negedge clk);
    req_n[1] = 1'b0;
    @(negedge clk);
    req_n[1] = 1'b1;
    repeat (L - 2) @(negedge clk);
    check(rst_main, 1'b0, "R8 before pulse");
    @(negedge clk);
    check(rst_main, 1'b1, "R8 pulse");
    @(negedge clk);
    check(rst_main, 1'b0, "R8 pulse width");
  endtask

  task automatic t_no_restart();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      check(rst_main, 1'b0, "R6 stays low");
      check(rst_d0, 1'b0, "R6 stays low d0");
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1;
    t_powerup();
    for (int k = 0; k < int'(N); k++) t_single(k);
    t_overlap();
    t_pulse();
    t_no_restart();
    finish_run();
  end

  initial begin
    #(4 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule